// File: doc/BRIEF.md
# Two-Cycle Delay Test Sequencer

This controller applies transition-delay tests to a multiplexer-based scan chain whose cells can also invert the value they capture. One stored test is handed over on a start/ready handshake: a scan state, a primary-input vector for the first cycle after scan-in, a primary-input vector for the second cycle, and a 6-bit apply mask. For every mask bit that is set, the sequencer runs one two-cycle test. The first cycle is the launch and the second is a functional capture. The captured state then comes back on a serial response output, tagged with the index of the test that produced it.

The launch cycle has six variants, indexed 0 to 5. Indices 0 and 1 launch by a single shift, with a serial fill of 0 and 1 respectively. Index 2 launches with a functional capture. Indices 3, 4 and 5 repeat 0, 1 and 2 with the complement control raised, so the chain cells fitted with inversion logic store the inverted value. The chain is driven through a pair of controls written {scan_en, comp_en}: 00 is functional capture, 10 is plain shift, 01 is inverted capture and 11 is inverted shift. The scan-out of one test runs in the same shift cycles as the scan-in of the next test, which loads the same stored state again.

Top module: `twocycle_test_seq`

## Requirements
- R1: After reset, ready is 1 and scan_en, comp_en, resp_valid and done are all 0.
- R2: Each scan-in lasts K cycles with controls 10. scan_si carries test_state[K-1] first and test_state[0] last, so bit i ends up in chain cell i (cell 0 is fed by scan_si, and cell K-1 drives chain_so).
- R3: For tests 0 and 1, the launch cycle has controls 10 and scan_si is 0 for test 0 and 1 for test 1.
- R4: For test 2, the launch cycle has controls 00. The first primary-input vector is on pi_out during scan-in and launch.
- R5: Tests 3, 4 and 5 behave like tests 0, 1 and 2, except that comp_en is 1 during the launch cycle. comp_en is never 1 in any other cycle.
- R6: The cycle after every launch is a functional capture with controls 00 and the second primary-input vector on pi_out.
- R7: After each capture, K scan-out cycles follow with controls 10 and resp_valid=1. resp_bit equals chain_so, so captured cell K-1 comes out first. resp_test gives the index of the test being unloaded.
- R8: When another enabled test follows, its scan-in takes place in the same K cycles as the current scan-out. A run with n enabled tests (n>0) therefore takes K + n·(K+2) cycles from the accepting edge to the edge that raises done.
- R9: Tests run in ascending index order. Indices whose mask bit is 0 are skipped.
- R10: done is a one-cycle pulse that appears together with ready after the last scan-out. With an all-zero mask, done appears in the cycle right after start is accepted, and no shift takes place.
- R11: start and the test inputs are ignored while ready is 0. The running test's responses do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to load a stored test (taken when ready) |
| ready | output | 1 | Sequencer idle, start is accepted |
| test_state | input | K | Scan-in state of the stored test |
| test_pi0 | input | P | Primary inputs for the launch cycle |
| test_pi1 | input | P | Primary inputs for the capture cycle |
| apply_mask | input | 6 | Bit j set: apply test variant j |
| scan_en | output | 1 | Chain shift select |
| comp_en | output | 1 | Chain inversion select |
| scan_si | output | 1 | Serial data into chain cell 0 |
| pi_out | output | P | Primary-input vector to the logic under test |
| chain_so | input | 1 | Serial output of chain cell K-1 |
| resp_bit | output | 1 | Captured response bit |
| resp_valid | output | 1 | resp_bit holds a response bit |
| resp_test | output | 3 | Index of the test whose response is shifted out |
| done | output | 1 | One-cycle pulse when all enabled tests have finished |

## Verification
Unloading one test's captured state and loading the next test's scan state share the same shift cycles. Every mask with two or more bits set exercises this overlap. The bench drives all 64 masks against a behavioural chain with a known next-state function and a fixed set of inverting cells. A corrupted scan-in or a mistimed unload shows up as a wrong captured word for the following test. Each unload is compared with the word the bench computes arithmetically from the stored state, the launch variant and both input vectors. The cycle count from the start edge to done is compared with K + n·(K+2).

// File: rtl/lct_pkg.sv
// Shared types for the two-cycle delay test sequencer.
// Assumes six launch variants: three base kinds times inversion off/on.
package lct_pkg;
    localparam int NUM_TYPES = 6;
    localparam int BASE_KINDS = 3;
    localparam int TIDX_W = 3;

    typedef logic [TIDX_W-1:0] tidx_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SHIFT,
        PH_LAUNCH,
        PH_CAPT
    } phase_t;

    typedef struct packed {
        logic se;    // launch by shift
        logic ce;    // inversion during launch
        logic fill;  // serial value shifted in at launch
    } launch_ctl_t;
endpackage

// File: rtl/lct_pick.sv
// Finds the lowest set mask bit at or above index lo.
// Assumes N fits in W bits; lo may equal N, which means "none left".
module lct_pick #(
    parameter int N = 6,
    parameter int W = 3
) (
    input  logic [N-1:0] mask,
    input  logic [W-1:0] lo,
    output logic         found,
    output logic [W-1:0] idx
);
    // Scan from the top down so that the lowest qualifying bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(lo))) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/lct_launch_dec.sv
// Decodes a test index into the launch-cycle controls.
// Assumes index = kind + 3*invert, with kind 0/1 = shift with fill 0/1, kind 2 = capture.
module lct_launch_dec
    import lct_pkg::*;
(
    input  tidx_t       tidx,
    output launch_ctl_t ctl
);
    tidx_t kind;

    // Split the index into base kind and inversion flag.
    always_comb begin
        ctl.ce   = (tidx >= tidx_t'(BASE_KINDS));
        kind     = ctl.ce ? tidx - tidx_t'(BASE_KINDS) : tidx;
        ctl.se   = (kind != tidx_t'(2));
        ctl.fill = (kind == tidx_t'(1));
    end
endmodule

// File: rtl/lct_hold.sv
// Holds the stored test for the duration of a run and serialises its state.
// Assumes load is only raised when the sequencer is idle.
module lct_hold #(
    parameter int K  = 8,
    parameter int P  = 4,
    parameter int NT = 6,
    localparam int CW = (K > 1) ? $clog2(K) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [K-1:0]  state_in,
    input  logic [P-1:0]  pi0_in,
    input  logic [P-1:0]  pi1_in,
    input  logic [NT-1:0] mask_in,
    input  logic [CW-1:0] sel,
    output logic          st_bit,
    output logic [P-1:0]  pi0_q,
    output logic [P-1:0]  pi1_q,
    output logic [NT-1:0] mask_q
);
    logic [K-1:0] state_q;

    // Capture the stored test on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            pi0_q   <= '0;
            pi1_q   <= '0;
            mask_q  <= '0;
        end else if (load) begin
            state_q <= state_in;
            pi0_q   <= pi0_in;
            pi1_q   <= pi1_in;
            mask_q  <= mask_in;
        end
    end

    // Highest cell first: shift count 0 presents bit K-1.
    assign st_bit = state_q[CW'(K - 1) - sel];
endmodule

// File: rtl/twocycle_test_seq.sv
// Sequencer for launch-on-shift / launch-on-capture delay tests.
// Assumes the chain shifts from cell 0 towards cell K-1 and chain_so is cell K-1.
module twocycle_test_seq
    import lct_pkg::*;
#(
    parameter int K = 8,
    parameter int P = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    output logic                 ready,
    input  logic [K-1:0]         test_state,
    input  logic [P-1:0]         test_pi0,
    input  logic [P-1:0]         test_pi1,
    input  logic [NUM_TYPES-1:0] apply_mask,
    output logic                 scan_en,
    output logic                 comp_en,
    output logic                 scan_si,
    output logic [P-1:0]         pi_out,
    input  logic                 chain_so,
    output logic                 resp_bit,
    output logic                 resp_valid,
    output logic [TIDX_W-1:0]    resp_test,
    output logic                 done
);
    localparam int CW = (K > 1) ? $clog2(K) : 1;

    phase_t                phase;
    logic [CW-1:0]         cnt;
    tidx_t                 cur_j;
    tidx_t                 out_j;
    logic                  loading;
    logic                  unloading;
    logic                  done_q;
    logic                  st_bit;
    logic [P-1:0]          pi0_q;
    logic [P-1:0]          pi1_q;
    logic [NUM_TYPES-1:0]  mask_q;
    logic [NUM_TYPES-1:0]  pk_mask;
    tidx_t                 pk_lo;
    logic                  pk_found;
    tidx_t                 pk_idx;
    launch_ctl_t           lctl;
    logic                  last_shift;

    assign ready      = (phase == PH_IDLE);
    assign last_shift = (cnt == CW'(K - 1));

    lct_hold #(.K(K), .P(P), .NT(NUM_TYPES)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ready && start),
        .state_in (test_state),
        .pi0_in   (test_pi0),
        .pi1_in   (test_pi1),
        .mask_in  (apply_mask),
        .sel      (cnt),
        .st_bit   (st_bit),
        .pi0_q    (pi0_q),
        .pi1_q    (pi1_q),
        .mask_q   (mask_q)
    );

    // Idle: search the incoming mask from 0; busy: search above the current test.
    assign pk_mask = ready ? apply_mask : mask_q;
    assign pk_lo   = ready ? '0 : cur_j + tidx_t'(1);

    lct_pick #(.N(NUM_TYPES), .W(TIDX_W)) u_pick (
        .mask  (pk_mask),
        .lo    (pk_lo),
        .found (pk_found),
        .idx   (pk_idx)
    );

    lct_launch_dec u_dec (
        .tidx (cur_j),
        .ctl  (lctl)
    );

    // Phase sequencing: shift window, launch, capture, next shift window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            cur_j     <= '0;
            out_j     <= '0;
            loading   <= 1'b0;
            unloading <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        if (pk_found) begin
                            phase     <= PH_SHIFT;
                            cnt       <= '0;
                            loading   <= 1'b1;
                            unloading <= 1'b0;
                            cur_j     <= pk_idx;
                        end else begin
                            done_q <= 1'b1;
                        end
                    end
                end
                PH_SHIFT: begin
                    if (last_shift) begin
                        cnt       <= '0;
                        loading   <= 1'b0;
                        unloading <= 1'b0;
                        if (loading) begin
                            phase <= PH_LAUNCH;
                        end else begin
                            phase  <= PH_IDLE;
                            done_q <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_LAUNCH: phase <= PH_CAPT;
                PH_CAPT: begin
                    phase     <= PH_SHIFT;
                    cnt       <= '0;
                    unloading <= 1'b1;
                    out_j     <= cur_j;
                    loading   <= pk_found;
                    if (pk_found) cur_j <= pk_idx;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Chain controls and data, a pure function of the phase registers.
    always_comb begin
        scan_en = 1'b0;
        comp_en = 1'b0;
        scan_si = 1'b0;
        pi_out  = pi0_q;
        unique case (phase)
            PH_SHIFT: begin
                scan_en = 1'b1;
                scan_si = loading & st_bit;
            end
            PH_LAUNCH: begin
                scan_en = lctl.se;
                comp_en = lctl.ce;
                scan_si = lctl.se & lctl.fill;
            end
            PH_CAPT: pi_out = pi1_q;
            default: ;
        endcase
    end

    assign resp_valid = (phase == PH_SHIFT) && unloading;
    assign resp_bit   = chain_so & resp_valid;
    assign resp_test  = out_j;
    assign done       = done_q;

    // R5
    comp_launch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        comp_en |=> !comp_en);

    // R6
    capture_after_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LAUNCH) |=> (!scan_en && !comp_en && pi_out == pi1_q));

    // R7
    unload_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (scan_en && !comp_en));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> $stable(mask_q));
endmodule

// File: tb/twocycle_test_seq_test.sv
// Bench: behavioural invertible scan chain plus sweep of all apply masks.
module twocycle_test_seq_test;
    localparam int K = 5;
    localparam int P = 2;
    localparam int PERIOD = 10;
    localparam logic [K-1:0] CSET = 5'b00100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ready;
    logic [K-1:0] test_state = '0;
    logic [P-1:0] test_pi0 = '0;
    logic [P-1:0] test_pi1 = '0;
    logic [5:0] apply_mask = '0;
    logic scan_en, comp_en, scan_si;
    logic [P-1:0] pi_out;
    logic chain_so;
    logic resp_bit, resp_valid;
    logic [2:0] resp_test;
    logic done;
    logic [K-1:0] chain = '0;
    int total = 0;
    int bad = 0;

    always #(PERIOD/2) clk = ~clk;

    twocycle_test_seq #(.K(K), .P(P)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
        .test_state(test_state), .test_pi0(test_pi0), .test_pi1(test_pi1),
        .apply_mask(apply_mask), .scan_en(scan_en), .comp_en(comp_en),
        .scan_si(scan_si), .pi_out(pi_out), .chain_so(chain_so),
        .resp_bit(resp_bit), .resp_valid(resp_valid), .resp_test(resp_test),
        .done(done)
    );

    function automatic logic [K-1:0] nxt(logic [K-1:0] y, logic [P-1:0] v);
        logic [K-1:0] r;
        for (int i = 0; i < K; i++)
            r[i] = y[(i+1)%K] ^ (y[i] & v[i%P]) ^ v[(i+1)%P];
        return r;
    endfunction

    // Behavioural chain: 00 capture, 10 shift, 01/11 same with inversion on CSET cells.
    always @(posedge clk) begin
        logic [K-1:0] f;
        f = scan_en ? {chain[K-2:0], scan_si} : nxt(chain, pi_out);
        chain <= comp_en ? (f ^ CSET) : f;
    end
    assign chain_so = chain[K-1];

    function automatic logic [K-1:0] expect_resp(logic [K-1:0] s, logic [P-1:0] a,
                                                 logic [P-1:0] b, int j);
        logic [K-1:0] s1;
        int kind;
        kind = j % 3;
        if (kind == 2) s1 = nxt(s, a);
        else s1 = {s[K-2:0], (kind == 1)};
        if (j >= 3) s1 = s1 ^ CSET;
        return nxt(s1, b);
    endfunction

    function automatic int nextset(logic [5:0] m, int from);
        for (int i = from; i < 6; i++) if (m[i]) return i;
        return 6;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_one(logic [K-1:0] s, logic [P-1:0] a, logic [P-1:0] b,
                           logic [5:0] m, bit disturb);
        int cyc, nb, ej, n;
        logic [K-1:0] word;
        logic [2:0] tj;
        n = $countones(m);
        @(negedge clk);
        test_state = s; test_pi0 = a; test_pi1 = b; apply_mask = m; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0; nb = 0; ej = nextset(m, 0); word = '0; tj = '0;
        while (!done && cyc < 2000) begin
            if (resp_valid) begin
                if (nb == 0) tj = resp_test;
                word = {word[K-2:0], resp_bit};
                nb++;
                if (nb == K) begin
                    // R9: ascending order, cleared bits skipped
                    chk(int'(tj) == ej, "R9 test order", int'(tj), ej);
                    // R2 R3 R4 R5 R6 R7 R8: captured word for this variant
                    chk(word == expect_resp(s, a, b, ej), "R2 R3 R4 R5 R6 R7 R8 response",
                        int'(word), int'(expect_resp(s, a, b, ej)));
                    ej = nextset(m, ej + 1);
                    nb = 0;
                end
            end
            if (disturb && cyc == 3) begin
                // R11: busy start with different data
                start = 1'b1; apply_mask = ~m; test_state = ~s; test_pi0 = ~a;
            end
            if (disturb && cyc == 6) start = 1'b0;
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        // R8 R10: cycle count to done
        chk(cyc == ((n == 0) ? 0 : K + n * (K + 2)), "R8 R10 run length", cyc,
            (n == 0) ? 0 : K + n * (K + 2));
        // R10: ready with done
        chk(ready == 1'b1, "R10 ready at done", int'(ready), 1);
        // R9 R11: every enabled test unloaded, nothing extra
        chk(ej == 6, "R9 R11 all tests seen", ej, 6);
        @(posedge clk);
        @(negedge clk);
        // R10: single-cycle pulse
        chk(done == 1'b0, "R10 done pulse width", int'(done), 0);
    endtask

    initial begin
        #(PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(ready == 1'b1, "R1 ready", int'(ready), 1);
        chk(scan_en == 1'b0 && comp_en == 1'b0, "R1 controls", int'({scan_en, comp_en}), 0);
        chk(resp_valid == 1'b0, "R1 resp_valid", int'(resp_valid), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        for (int m = 0; m < 64; m++) begin
            run_one(5'b10110, 2'b01, 2'b10, 6'(m), (m % 7) == 3);
            run_one(5'b01101, 2'b11, 2'b00, 6'(m), (m % 5) == 1);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule